// File: doc/BRIEF.md
# CAN Message Buffer Code Controller

This block keeps the 4-bit lifecycle code and the remote-frame flag for a single CAN message buffer. It moves the code forward when receive or transmit events arrive. A matching engine sends pulses when it starts and finishes writing a received frame into the buffer. It also sends a pulse when an incoming remote request matches the buffer's identifier. The transmit side sends a pulse when a frame from this buffer has gone out successfully. The CPU can load a new code and flag at any time. It can also lock the buffer by reading its control/status word and release it with an unlock strobe.

The outputs are the current code, the stored remote flag, a busy indication that is high while a frame is being written, and an arbitration-eligible flag. A buffer arbiter elsewhere uses that flag to decide which buffers compete for the bus. Bit timing, identifier comparison, arbitration, payload storage and any receive FIFO belong to other blocks.

Top module: `mbcode_unit`

## Requirements
- R1: While reset is asserted, and right after it is released, code is 0000, rtr is 0, busy is 0 and arbEligible is 0.
- R2: A cpuWrEn pulse loads cpuWrCode and cpuWrRtr into code and rtr on the next clock edge. It takes precedence over any hardware event pulse in the same cycle.
- R3: A CPU write of 1001 (abort) is stored as 1001 when abortEn is 1, and as 1000 (transmit inactive) when abortEn is 0. Neither code drives arbEligible.
- R4: With code 0100 (empty), a frmStart pulse moves the code to 0011, and busy goes high. A following frmEnd pulse moves it to 0010 (full), and busy goes low.
- R5: With code 0010 or 0110 (overrun), a frmStart pulse moves the code to 0111, and busy goes high. A following frmEnd pulse moves it to 0110. This also applies to an overrun buffer that is overwritten again.
- R6: A csRead pulse locks the buffer until an unlock pulse. While the buffer is locked, frmStart has no effect on code or busy.
- R7: If a full or overrun buffer is read with csRead and then released with unlock, the next frame follows the 0011 then 0010 path and ends full.
- R8: With code 1100, a txDone pulse moves the code to 1000 when rtr is 0. When rtr is 1, it moves the code to 0100 and rtr stays 1.
- R9: With code 1010, a remoteMatch pulse moves the code to 1110. With code 1110, whether set by a match or by a CPU write, a txDone pulse moves it back to 1010.
- R10: arbEligible is high exactly when code is 1100 or 1110. busy is high exactly when code is 0011 or 0111.
- R11: An event pulse that does not apply to the current code leaves the code unchanged. Examples are txDone at 1000 or 1010, remoteMatch at 1001, and frmStart at 1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpuWrEn | input | 1 | CPU write strobe for code and flag |
| cpuWrCode | input | 4 | Code value written by the CPU |
| cpuWrRtr | input | 1 | Remote flag written by the CPU |
| csRead | input | 1 | CPU read of the control/status word (takes the lock) |
| unlock | input | 1 | CPU releases the lock |
| frmStart | input | 1 | Matching engine begins writing a received frame |
| frmEnd | input | 1 | Matching engine finished writing the frame |
| remoteMatch | input | 1 | An incoming remote request matched this buffer |
| txDone | input | 1 | A frame from this buffer was transmitted successfully |
| abortEn | input | 1 | Abort code enable |
| code | output | 4 | Current buffer code |
| rtr | output | 1 | Stored remote flag |
| busy | output | 1 | Buffer is being written by the matching engine |
| arbEligible | output | 1 | Buffer may take part in transmit arbitration |

## Verification
Code and rtr are held in registers. Any strobe is therefore visible exactly one clock edge later. busy and arbEligible are decoded from the registered code, so they change in that same cycle. The bench drives each stimulus on a falling edge and holds it through one rising edge. It then compares all four outputs on the next falling edge, which is the first point where the single register stage has updated. Reset is asynchronous, so the reset checks are sampled shortly after rst_n falls, without waiting for a clock.

// File: rtl/mbcode_pkg.sv
package mbcode_pkg;
  localparam int CODE_W = 4;

  localparam logic [CODE_W-1:0] C_RX_INACT = 4'b0000;
  localparam logic [CODE_W-1:0] C_EMPTY    = 4'b0100;
  localparam logic [CODE_W-1:0] C_FULL     = 4'b0010;
  localparam logic [CODE_W-1:0] C_OVERRUN  = 4'b0110;
  localparam logic [CODE_W-1:0] C_BUSY_E   = 4'b0011;
  localparam logic [CODE_W-1:0] C_BUSY_O   = 4'b0111;
  localparam logic [CODE_W-1:0] C_TX_INACT = 4'b1000;
  localparam logic [CODE_W-1:0] C_ABORT    = 4'b1001;
  localparam logic [CODE_W-1:0] C_TX_ONCE  = 4'b1100;
  localparam logic [CODE_W-1:0] C_RR_WAIT  = 4'b1010;
  localparam logic [CODE_W-1:0] C_RR_SEND  = 4'b1110;

  typedef struct packed {
    logic              loadCode;
    logic [CODE_W-1:0] nextCode;
    logic              loadRtr;
    logic              rtrVal;
    logic              lockSet;
    logic              lockClr;
    logic              servSet;
    logic              servClr;
  } mbStrobe_t;
endpackage

// File: rtl/mbcode_ctrl.sv
module mbcode_ctrl
  import mbcode_pkg::*;
(
  input  logic [CODE_W-1:0] codeQ,
  input  logic              rtrQ,
  input  logic              lockQ,
  input  logic              servQ,
  input  logic              cpuWrEn,
  input  logic [CODE_W-1:0] cpuWrCode,
  input  logic              cpuWrRtr,
  input  logic              csRead,
  input  logic              unlock,
  input  logic              frmStart,
  input  logic              frmEnd,
  input  logic              remoteMatch,
  input  logic              txDone,
  input  logic              abortEn,
  output mbStrobe_t         strb
);
  logic rxHeld;
  logic startOk;

  assign rxHeld  = (codeQ == C_FULL) || (codeQ == C_OVERRUN);
  assign startOk = frmStart && !lockQ;

  always_comb begin
    strb          = '0;
    strb.lockSet  = csRead;
    strb.lockClr  = unlock && !csRead;
    strb.servSet  = unlock && !csRead && lockQ && rxHeld;
    if (cpuWrEn) begin
      strb.loadCode = 1'b1;
      strb.nextCode = ((cpuWrCode == C_ABORT) && !abortEn) ? C_TX_INACT : cpuWrCode;
      strb.loadRtr  = 1'b1;
      strb.rtrVal   = cpuWrRtr;
      strb.servSet  = 1'b0;
      strb.servClr  = 1'b1;
    end else begin
      unique case (codeQ)
        C_EMPTY: begin
          if (startOk) begin
            strb.loadCode = 1'b1;
            strb.nextCode = C_BUSY_E;
          end
        end
        C_FULL, C_OVERRUN: begin
          if (startOk) begin
            strb.loadCode = 1'b1;
            strb.nextCode = servQ ? C_BUSY_E : C_BUSY_O;
            strb.servClr  = 1'b1;
          end
        end
        C_BUSY_E: begin
          if (frmEnd) begin
            strb.loadCode = 1'b1;
            strb.nextCode = C_FULL;
          end
        end
        C_BUSY_O: begin
          if (frmEnd) begin
            strb.loadCode = 1'b1;
            strb.nextCode = C_OVERRUN;
          end
        end
        C_TX_ONCE: begin
          if (txDone) begin
            strb.loadCode = 1'b1;
            strb.nextCode = rtrQ ? C_EMPTY : C_TX_INACT;
          end
        end
        C_RR_WAIT: begin
          if (remoteMatch) begin
            strb.loadCode = 1'b1;
            strb.nextCode = C_RR_SEND;
          end
        end
        C_RR_SEND: begin
          if (txDone) begin
            strb.loadCode = 1'b1;
            strb.nextCode = C_RR_WAIT;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mbcode_dp.sv
module mbcode_dp
  import mbcode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  mbStrobe_t         strb,
  output logic [CODE_W-1:0] codeQ,
  output logic              rtrQ,
  output logic              lockQ,
  output logic              servQ,
  output logic              busyOut,
  output logic              arbOut
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      codeQ <= C_RX_INACT;
      rtrQ  <= 1'b0;
      lockQ <= 1'b0;
      servQ <= 1'b0;
    end else begin
      if (strb.loadCode) codeQ <= strb.nextCode;
      if (strb.loadRtr)  rtrQ  <= strb.rtrVal;
      if (strb.lockSet)      lockQ <= 1'b1;
      else if (strb.lockClr) lockQ <= 1'b0;
      if (strb.servClr)      servQ <= 1'b0;
      else if (strb.servSet) servQ <= 1'b1;
    end
  end

  assign busyOut = (codeQ == C_BUSY_E) || (codeQ == C_BUSY_O);
  assign arbOut  = (codeQ == C_TX_ONCE) || (codeQ == C_RR_SEND);
endmodule

// File: rtl/mbcode_unit.sv
module mbcode_unit
  import mbcode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpuWrEn,
  input  logic [CODE_W-1:0] cpuWrCode,
  input  logic              cpuWrRtr,
  input  logic              csRead,
  input  logic              unlock,
  input  logic              frmStart,
  input  logic              frmEnd,
  input  logic              remoteMatch,
  input  logic              txDone,
  input  logic              abortEn,
  output logic [CODE_W-1:0] code,
  output logic              rtr,
  output logic              busy,
  output logic              arbEligible
);
  mbStrobe_t         strb;
  logic [CODE_W-1:0] codeQ;
  logic              rtrQ;
  logic              lockQ;
  logic              servQ;

  mbcode_ctrl u_ctrl (
    .codeQ(codeQ), .rtrQ(rtrQ), .lockQ(lockQ), .servQ(servQ),
    .cpuWrEn(cpuWrEn), .cpuWrCode(cpuWrCode), .cpuWrRtr(cpuWrRtr),
    .csRead(csRead), .unlock(unlock), .frmStart(frmStart), .frmEnd(frmEnd),
    .remoteMatch(remoteMatch), .txDone(txDone), .abortEn(abortEn),
    .strb(strb)
  );

  mbcode_dp u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .codeQ(codeQ), .rtrQ(rtrQ), .lockQ(lockQ), .servQ(servQ),
    .busyOut(busy), .arbOut(arbEligible)
  );

  assign code = codeQ;
  assign rtr  = rtrQ;
endmodule

// File: rtl/mbcode_chk.sv
module mbcode_chk
  import mbcode_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cpuWrEn,
  input logic [CODE_W-1:0] cpuWrCode,
  input logic              cpuWrRtr,
  input logic              frmEnd,
  input logic              remoteMatch,
  input logic              txDone,
  input logic              abortEn,
  input logic [CODE_W-1:0] code,
  input logic              rtr,
  input logic              busy,
  input logic              arbEligible
);
  a_r2_cpu_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cpuWrEn && !((cpuWrCode == C_ABORT) && !abortEn))
      |=> (code == $past(cpuWrCode)) && (rtr == $past(cpuWrRtr)));

  a_r3_abort_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (cpuWrEn && (cpuWrCode == C_ABORT) && !abortEn) |=> (code == C_TX_INACT));

  a_r4_busy_to_full: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpuWrEn && (code == C_BUSY_E) && frmEnd) |=> (code == C_FULL) && !busy);

  a_r5_busy_to_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpuWrEn && (code == C_BUSY_O) && frmEnd) |=> (code == C_OVERRUN) && !busy);

  a_r8_data_once: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpuWrEn && (code == C_TX_ONCE) && !rtr && txDone) |=> (code == C_TX_INACT));

  a_r9_remote_match: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpuWrEn && (code == C_RR_WAIT) && remoteMatch) |=> (code == C_RR_SEND) && arbEligible);

  a_r10_busy_excl_arb: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !arbEligible);

  a_r11_inactive_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpuWrEn && (code == C_TX_INACT)) |=> $stable(code));
endmodule

bind mbcode_unit mbcode_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpuWrEn(cpuWrEn), .cpuWrCode(cpuWrCode),
  .cpuWrRtr(cpuWrRtr), .frmEnd(frmEnd), .remoteMatch(remoteMatch),
  .txDone(txDone), .abortEn(abortEn), .code(code), .rtr(rtr),
  .busy(busy), .arbEligible(arbEligible)
);

// File: tb/sim_mbcode_unit.sv
`timescale 1ns/1ps
module sim_mbcode_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpuWrEn = 0, cpuWrRtr = 0, csRead = 0, unlock = 0;
  logic       frmStart = 0, frmEnd = 0, remoteMatch = 0, txDone = 0, abortEn = 0;
  logic [3:0] cpuWrCode = 4'h0;
  logic [3:0] code;
  logic       rtr, busy, arbEligible;
  int         nChecks = 0;
  int         nFails = 0;

  always #5 clk = ~clk;

  mbcode_unit u0 (
    .clk(clk), .rst_n(rst_n), .cpuWrEn(cpuWrEn), .cpuWrCode(cpuWrCode),
    .cpuWrRtr(cpuWrRtr), .csRead(csRead), .unlock(unlock), .frmStart(frmStart),
    .frmEnd(frmEnd), .remoteMatch(remoteMatch), .txDone(txDone), .abortEn(abortEn),
    .code(code), .rtr(rtr), .busy(busy), .arbEligible(arbEligible)
  );

  // vector: {req[3:0], wr, wc[3:0], wrr, rd, ul, fs, fe, rr, td, ae, ec[3:0], er, eb, ea}
  function automatic logic [23:0] v(input logic [3:0] req, input logic wr, input logic [3:0] wc,
                                    input logic wrr, input logic rd, input logic ul,
                                    input logic fs, input logic fe, input logic rr,
                                    input logic td, input logic ae, input logic [3:0] ec,
                                    input logic er, input logic eb, input logic ea);
    return {req, wr, wc, wrr, rd, ul, fs, fe, rr, td, ae, ec, er, eb, ea};
  endfunction

  localparam int NV = 26;
  localparam logic [23:0] VEC [NV] = '{
    //  req wr  wc    wrr rd ul fs fe rr td ae  ec     er eb ea
    v(4'd2, 1, 4'h4, 0, 0, 0, 0, 0, 0, 0, 0, 4'h4, 0, 0, 0), // R2 write empty
    v(4'd4, 0, 4'h0, 0, 0, 0, 1, 0, 0, 0, 0, 4'h3, 0, 1, 0), // R4 R10 busy
    v(4'd4, 0, 4'h0, 0, 0, 0, 0, 1, 0, 0, 0, 4'h2, 0, 0, 0), // R4 full
    v(4'd5, 0, 4'h0, 0, 0, 0, 1, 0, 0, 0, 0, 4'h7, 0, 1, 0), // R5 overwrite
    v(4'd5, 0, 4'h0, 0, 0, 0, 0, 1, 0, 0, 0, 4'h6, 0, 0, 0), // R5 overrun
    v(4'd5, 0, 4'h0, 0, 0, 0, 1, 0, 0, 0, 0, 4'h7, 0, 1, 0), // R5 again
    v(4'd5, 0, 4'h0, 0, 0, 0, 0, 1, 0, 0, 0, 4'h6, 0, 0, 0), // R5 stays overrun
    v(4'd6, 0, 4'h0, 0, 1, 0, 0, 0, 0, 0, 0, 4'h6, 0, 0, 0), // R6 lock
    v(4'd6, 0, 4'h0, 0, 0, 0, 1, 0, 0, 0, 0, 4'h6, 0, 0, 0), // R6 start ignored
    v(4'd7, 0, 4'h0, 0, 0, 1, 0, 0, 0, 0, 0, 4'h6, 0, 0, 0), // R7 unlock
    v(4'd7, 0, 4'h0, 0, 0, 0, 1, 0, 0, 0, 0, 4'h3, 0, 1, 0), // R7 empty path
    v(4'd7, 0, 4'h0, 0, 0, 0, 0, 1, 0, 0, 0, 4'h2, 0, 0, 0), // R7 full
    v(4'd2, 1, 4'hC, 0, 0, 0, 1, 0, 0, 0, 0, 4'hC, 0, 0, 1), // R2 precedence, R10 arb
    v(4'd8, 0, 4'h0, 0, 0, 0, 0, 0, 0, 1, 0, 4'h8, 0, 0, 0), // R8 data once
    v(4'd11,0, 4'h0, 0, 0, 0, 0, 0, 0, 1, 0, 4'h8, 0, 0, 0), // R11 txDone at 1000
    v(4'd2, 1, 4'hC, 1, 0, 0, 0, 0, 0, 0, 0, 4'hC, 1, 0, 1), // R2 remote once
    v(4'd8, 0, 4'h0, 0, 0, 0, 0, 0, 0, 1, 0, 4'h4, 1, 0, 0), // R8 becomes empty
    v(4'd9, 1, 4'hA, 0, 0, 0, 0, 0, 0, 0, 0, 4'hA, 0, 0, 0), // R9 wait
    v(4'd11,0, 4'h0, 0, 0, 0, 0, 0, 0, 1, 0, 4'hA, 0, 0, 0), // R11 txDone at 1010
    v(4'd9, 0, 4'h0, 0, 0, 0, 0, 0, 1, 0, 0, 4'hE, 0, 0, 1), // R9 match
    v(4'd9, 0, 4'h0, 0, 0, 0, 0, 0, 0, 1, 0, 4'hA, 0, 0, 0), // R9 back
    v(4'd9, 1, 4'hE, 0, 0, 0, 0, 0, 0, 0, 0, 4'hE, 0, 0, 1), // R9 cpu 1110
    v(4'd9, 0, 4'h0, 0, 0, 0, 0, 0, 0, 1, 0, 4'hA, 0, 0, 0), // R9 back
    v(4'd3, 1, 4'h9, 0, 0, 0, 0, 0, 0, 0, 0, 4'h8, 0, 0, 0), // R3 abort gated
    v(4'd3, 1, 4'h9, 0, 0, 0, 0, 0, 0, 0, 1, 4'h9, 0, 0, 0), // R3 abort kept
    v(4'd11,0, 4'h0, 0, 0, 0, 0, 0, 1, 0, 1, 4'h9, 0, 0, 0)  // R11 match at 1001
  };

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: {code,rtr,busy,arb} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic clearIns();
    cpuWrEn = 0; cpuWrCode = 4'h0; cpuWrRtr = 0; csRead = 0; unlock = 0;
    frmStart = 0; frmEnd = 0; remoteMatch = 0; txDone = 0; abortEn = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {code, rtr, busy, arbEligible}, 7'b0000_000); // R1 in reset
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {code, rtr, busy, arbEligible}, 7'b0000_000); // R1 after release

    for (int i = 0; i < NV; i++) begin
      logic [23:0] w;
      w = VEC[i];
      {cpuWrEn, cpuWrCode, cpuWrRtr, csRead, unlock, frmStart, frmEnd,
       remoteMatch, txDone, abortEn} = w[19:7];
      @(posedge clk);
      @(negedge clk);
      clearIns();
      check($sformatf("R%0d vec %0d", w[23:20], i), {code, rtr, busy, arbEligible}, w[6:0]);
    end

    // R6 locked buffer from empty: start ignored until unlock
    cpuWrEn = 1; cpuWrCode = 4'h4;
    @(posedge clk); @(negedge clk); clearIns();
    csRead = 1;
    @(posedge clk); @(negedge clk); clearIns();
    frmStart = 1;
    @(posedge clk); @(negedge clk); clearIns();
    check("R6 empty locked", {code, rtr, busy, arbEligible}, 7'b0100_000);
    unlock = 1;
    @(posedge clk); @(negedge clk); clearIns();
    frmStart = 1;
    @(posedge clk); @(negedge clk); clearIns();
    check("R6 after unlock", {code, rtr, busy, arbEligible}, 7'b0011_010);

    // R11 frmStart at transmit inactive
    cpuWrEn = 1; cpuWrCode = 4'h8;
    @(posedge clk); @(negedge clk); clearIns();
    frmStart = 1;
    @(posedge clk); @(negedge clk); clearIns();
    check("R11 start at 1000", {code, rtr, busy, arbEligible}, 7'b1000_000);

    // R1 asynchronous reset mid-run
    cpuWrEn = 1; cpuWrCode = 4'hC; cpuWrRtr = 1;
    @(posedge clk); @(negedge clk); clearIns();
    rst_n = 1'b0;
    #1;
    check("R1 mid reset", {code, rtr, busy, arbEligible}, 7'b0000_000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 post reset", {code, rtr, busy, arbEligible}, 7'b0000_000);

    summary();
    $finish;
  end
endmodule